// File: doc/BRIEF.md
# Master/Slave Synchronous Serial Shifter

This block is a byte-wide synchronous serial port that shares three pins with a general-purpose I/O port: a shift clock, a serial input and a serial output. One shift register carries both directions. The byte written by the CPU leaves on the serial output, most significant bit first, while the same number of bits arrive from the serial input. In master mode the block makes the shift clock itself from a fixed division of the system clock. In slave mode it follows an external clock, which it passes through a synchroniser into the system clock domain and counts.

Software sees two registers. The control register sits at address 0 and the data register at address 1. While the port is enabled it takes over the direction of the clock pin and the serial-output pin. When it is disabled, all three pins go back to the direction bits kept by the general-purpose port. Transmit has a single buffer, so a data write during a transfer is dropped and flagged. Receive has two buffers: a completed byte is copied to a holding register, and if a byte has not been read before the next one completes, it is overwritten and the overrun is flagged.

Top module: `sio_port`

## Requirements
- R1: After reset the control register reads 0x00, the data register reads 0x00, sck_out is low, and pin_oe equals dir_reg.
- R2: When EN (control bit 0) is 0, pin_oe[2:0] equals dir_reg[2:0]. Index 0 is the clock pin, index 1 is serial in and index 2 is serial out.
- R3: When EN=1 and SLV (control bit 1) is 0, pin_oe[0]=1, pin_oe[2]=1 and pin_oe[1] follows dir_reg[1].
- R4: When EN=1 and SLV=1, pin_oe[0]=0, pin_oe[2]=1 and pin_oe[1] follows dir_reg[1].
- R5: In master mode, a control write with EN=1 and GO (bit 2) set, made while EN is already 1 and the port is idle, produces exactly 8 pulses on sck_out. Each pulse is active for DIV/2 system clocks. GO reads 1 during the transfer. At the end GO reads 0 and DONE (bit 4) is set.
- R6: In slave mode, a started transfer completes after 8 pulses on sck_in, which is taken through a synchroniser. DONE is then set and GO reads 0.
- R7: POL (bit 3) sets the idle clock level, which equals POL. In both modes serial in is sampled on the leading edge (leaving idle) and serial out changes on the trailing edge (returning to idle).
- R8: The byte written to address 1 goes out on sdo MSB first. In the same transfer 8 bits from sdi are shifted in, MSB first.
- R9: A write to address 1 while GO reads 1 is ignored and does not change the byte being sent. It sets WCOL (bit 5).
- R10: When a transfer completes, the received byte is copied into a holding buffer that is read at address 1. A write to address 1 does not change the value read there. If the held byte was not read (a read strobe at address 1) before the next transfer completes, it is overwritten and OVR (bit 6) is set.
- R11: A control write with EN=1 and GO=1 made while EN is 0 sets EN, starts no transfer, leaves GO reading 0 and leaves sck_out idle.
- R12: Writing 1 to DONE, WCOL or OVR clears that flag. Writing 0 to a flag leaves it unchanged. Starting a transfer clears DONE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (marks the held byte as read) |
| addr | input | 1 | 0 selects control, 1 selects data |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for the selected register |
| dir_reg | input | 3 | Direction bits from the general-purpose port (1 = output) |
| pin_oe | output | 3 | Resulting output enables for clock, serial in, serial out |
| sck_in | input | 1 | External shift clock (slave mode) |
| sck_out | output | 1 | Generated shift clock (master mode) |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |

## Verification
The embedded assertions check on every cycle the properties that do not depend on a scenario. The clock returns to the POL level whenever the port is idle. A completion only happens inside an active transfer. A transfer cannot begin from the disabled state. A data write during a transfer raises WCOL. A completion with an unread byte raises OVR. The holding buffer changes only at a completion. The shift register moves only on a trailing edge or a load. The bench scenarios show what no single-cycle property covers: the exact pulse count and pulse width, MSB-first full-duplex data in both modes and both polarities, and that a colliding write leaves the transmitted byte unchanged. They also show that overwritten bytes are reported, that the write-1-to-clear rules hold, and that pin directions are handed back when the port is disabled.

// File: rtl/sio_pkg.sv
`timescale 1ns/1ps
package sio_pkg;
   // control register bit positions (software visible)
   localparam int CB_EN   = 0;
   localparam int CB_SLV  = 1;
   localparam int CB_GO   = 2;
   localparam int CB_POL  = 3;
   localparam int CB_DONE = 4;
   localparam int CB_WCOL = 5;
   localparam int CB_OVR  = 6;
   localparam int CB_USED = 7;

   // shared pin indices
   localparam int PIN_SCK = 0;
   localparam int PIN_SDI = 1;
   localparam int PIN_SDO = 2;
   localparam int NPINS   = 3;

   typedef struct packed {
      logic pol;
      logic slv;
      logic en;
   } sio_mode_t;
endpackage

// File: rtl/sio_regs.sv
`timescale 1ns/1ps
module sio_regs
   import sio_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic              addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              done_pulse,
   input  logic [DATA_W-1:0] rx_byte,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] load_data,
   output sio_mode_t         mode,
   output logic              busy,
   output logic              load_pulse,
   output logic              start_pulse
);
   generate
      if (DATA_W < CB_USED) begin : g_bad_width
         $error("sio_regs: DATA_W must hold all control bits");
      end
   endgenerate

   logic              wr_ctrl, wr_data, rd_data;
   logic              done_q, wcol_q, ovr_q, rx_full;
   logic [DATA_W-1:0] rx_hold;
   logic [DATA_W-1:0] ctrl_img;

   assign wr_ctrl = wr_en & ~addr;
   assign wr_data = wr_en &  addr;
   assign rd_data = rd_en &  addr;

   // start is legal only when already enabled and idle
   assign start_pulse = wr_ctrl & mode.en & wdata[CB_EN] & wdata[CB_GO] & ~busy;
   assign load_pulse  = wr_data & ~busy;
   assign load_data   = wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode    <= '0;
         busy    <= 1'b0;
         done_q  <= 1'b0;
         wcol_q  <= 1'b0;
         ovr_q   <= 1'b0;
         rx_full <= 1'b0;
         rx_hold <= '0;
      end else begin
         if (wr_ctrl) begin
            mode.en  <= wdata[CB_EN];
            mode.slv <= wdata[CB_SLV];
            mode.pol <= wdata[CB_POL];
         end

         if (done_pulse)        busy <= 1'b0;
         else if (start_pulse)  busy <= 1'b1;
         else if (!mode.en)     busy <= 1'b0;

         if (start_pulse)                       done_q <= 1'b0;
         else if (done_pulse)                   done_q <= 1'b1;
         else if (wr_ctrl && wdata[CB_DONE])    done_q <= 1'b0;

         if (wr_data && busy)                   wcol_q <= 1'b1;
         else if (wr_ctrl && wdata[CB_WCOL])    wcol_q <= 1'b0;

         if (done_pulse && rx_full)             ovr_q <= 1'b1;
         else if (wr_ctrl && wdata[CB_OVR])     ovr_q <= 1'b0;

         if (done_pulse)        rx_full <= 1'b1;
         else if (rd_data)      rx_full <= 1'b0;

         if (done_pulse)        rx_hold <= rx_byte;
      end
   end

   always_comb begin
      ctrl_img          = '0;
      ctrl_img[CB_EN]   = mode.en;
      ctrl_img[CB_SLV]  = mode.slv;
      ctrl_img[CB_GO]   = busy;
      ctrl_img[CB_POL]  = mode.pol;
      ctrl_img[CB_DONE] = done_q;
      ctrl_img[CB_WCOL] = wcol_q;
      ctrl_img[CB_OVR]  = ovr_q;
   end

   assign rdata = addr ? rx_hold : ctrl_img;

   AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |-> busy);                                             // R5
   AST_NO_START_FROM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode.en && !busy) |=> !busy);                                   // R11
   AST_WCOL_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data && busy) |=> wcol_q);                                    // R9
   AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (done_pulse && rx_full) |=> ovr_q);                               // R10
   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !done_pulse |=> $stable(rx_hold));                                // R10
endmodule

// File: rtl/sio_clkgen.sv
`timescale 1ns/1ps
module sio_clkgen #(
   parameter int DIV         = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic busy,
   input  logic slv,
   input  logic pol,
   input  logic sck_in,
   input  logic sdi,
   output logic sck_out,
   output logic lead,
   output logic trail,
   output logic sdi_smp
);
   localparam int HALF = DIV / 2;

   generate
      if (DIV < 2 || (DIV % 2) != 0) begin : g_bad_div
         $error("sio_clkgen: DIV must be even and at least 2");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("sio_clkgen: SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic tick, sck_lvl, m_act;
   assign m_act = busy & ~slv;

   // master divider: one tick per half period
   generate
      if (HALF == 1) begin : g_nodiv
         assign tick = 1'b1;
      end else begin : g_div
         localparam int CW = $clog2(HALF);
         localparam logic [CW-1:0] TOP = CW'(HALF - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           cnt <= '0;
            else if (!m_act)      cnt <= '0;
            else if (cnt == TOP)  cnt <= '0;
            else                  cnt <= cnt + 1'b1;
         end
         assign tick = (cnt == TOP);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sck_lvl <= 1'b0;
      else if (!m_act)  sck_lvl <= pol;
      else if (tick)    sck_lvl <= ~sck_lvl;
   end

   logic m_lead, m_trail;
   assign m_lead  = m_act & tick & (sck_lvl == pol);
   assign m_trail = m_act & tick & (sck_lvl != pol);

   // slave path: synchronise clock and data together
   logic [SYNC_STAGES-1:0] sck_sy, sdi_sy;
   generate
      if (SYNC_STAGES == 1) begin : g_sync1
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sck_sy <= '0;
               sdi_sy <= '0;
            end else begin
               sck_sy <= sck_in;
               sdi_sy <= sdi;
            end
         end
      end else begin : g_syncn
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sck_sy <= '0;
               sdi_sy <= '0;
            end else begin
               sck_sy <= {sck_sy[SYNC_STAGES-2:0], sck_in};
               sdi_sy <= {sdi_sy[SYNC_STAGES-2:0], sdi};
            end
         end
      end
   endgenerate

   logic s_now, s_prev, s_act, s_lead, s_trail;
   assign s_now = sck_sy[SYNC_STAGES-1];
   assign s_act = busy & slv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s_prev <= 1'b0;
      else        s_prev <= s_now;
   end

   assign s_lead  = s_act & (s_prev == pol) & (s_now != pol);
   assign s_trail = s_act & (s_prev != pol) & (s_now == pol);

   assign lead    = slv ? s_lead  : m_lead;
   assign trail   = slv ? s_trail : m_trail;
   assign sdi_smp = slv ? sdi_sy[SYNC_STAGES-1] : sdi;
   assign sck_out = sck_lvl;

   AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      !m_act |=> (sck_out == $past(pol)));                              // R7
   AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(lead && trail));                                                // R5
endmodule

// File: rtl/sio_shift.sv
`timescale 1ns/1ps
module sio_shift #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              start,
   input  logic              lead,
   input  logic              trail,
   input  logic              sdi_smp,
   output logic              sdo,
   output logic              done_pulse,
   output logic [DATA_W-1:0] rx_byte
);
   localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   generate
      if (DATA_W < 2) begin : g_bad_w
         $error("sio_shift: DATA_W must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] sr;
   logic [CNT_W-1:0]  bitcnt;
   logic              smp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr     <= '0;
         bitcnt <= '0;
         smp    <= 1'b0;
      end else begin
         if (start)      bitcnt <= '0;
         else if (trail) bitcnt <= bitcnt + 1'b1;

         if (lead) smp <= sdi_smp;

         if (load)       sr <= load_data;
         else if (trail) sr <= {sr[DATA_W-2:0], smp};
      end
   end

   assign sdo        = sr[DATA_W-1];
   assign done_pulse = trail & (bitcnt == LAST);
   assign rx_byte    = {sr[DATA_W-2:0], smp};

   AST_SHIFT_ONLY_ON_TRAIL: assert property (@(posedge clk) disable iff (!rst_n)
      (!trail && !load) |=> $stable(sr));                               // R8
endmodule

// File: rtl/sio_pinmux.sv
`timescale 1ns/1ps
module sio_pinmux
   import sio_pkg::*;
(
   input  sio_mode_t        mode,
   input  logic [NPINS-1:0] dir_reg,
   output logic [NPINS-1:0] pin_oe
);
   always_comb begin
      pin_oe = dir_reg;
      if (mode.en) begin
         pin_oe[PIN_SCK] = ~mode.slv;
         pin_oe[PIN_SDO] = 1'b1;
         pin_oe[PIN_SDI] = dir_reg[PIN_SDI];
      end
   end
endmodule

// File: rtl/sio_port.sv
`timescale 1ns/1ps
module sio_port
   import sio_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int DIV         = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic              addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [2:0]        dir_reg,
   output logic [2:0]        pin_oe,
   input  logic              sck_in,
   output logic              sck_out,
   input  logic              sdi,
   output logic              sdo
);
   sio_mode_t         mode;
   logic              busy, load_pulse, start_pulse, done_pulse;
   logic              lead, trail, sdi_smp;
   logic [DATA_W-1:0] load_data, rx_byte;

   sio_regs #(.DATA_W(DATA_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .done_pulse(done_pulse), .rx_byte(rx_byte),
      .rdata(rdata), .load_data(load_data), .mode(mode), .busy(busy),
      .load_pulse(load_pulse), .start_pulse(start_pulse)
   );

   sio_clkgen #(.DIV(DIV), .SYNC_STAGES(SYNC_STAGES)) clkgen_i (
      .clk(clk), .rst_n(rst_n), .busy(busy), .slv(mode.slv), .pol(mode.pol),
      .sck_in(sck_in), .sdi(sdi), .sck_out(sck_out), .lead(lead),
      .trail(trail), .sdi_smp(sdi_smp)
   );

   sio_shift #(.DATA_W(DATA_W)) shift_i (
      .clk(clk), .rst_n(rst_n), .load(load_pulse), .load_data(load_data),
      .start(start_pulse), .lead(lead), .trail(trail), .sdi_smp(sdi_smp),
      .sdo(sdo), .done_pulse(done_pulse), .rx_byte(rx_byte)
   );

   sio_pinmux pinmux_i (
      .mode(mode), .dir_reg(dir_reg), .pin_oe(pin_oe)
   );
endmodule

// File: tb/sio_port_tb_top.sv
`timescale 1ns/1ps
module sio_port_tb_top;
   localparam int HALF_CYC = 2;   // DIV/2 at default DIV=4
   localparam int SHP      = 8;   // bench slave-clock half period in cycles
   localparam logic [7:0] C_EN = 8'h01, C_SLV = 8'h02, C_GO = 8'h04, C_POL = 8'h08,
                          C_DONE = 8'h10, C_WCOL = 8'h20, C_OVR = 8'h40;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
   logic [7:0] wdata = '0, rdata;
   logic [2:0] dir_reg = 3'b101, pin_oe;
   logic       sck_in = 1'b0, sck_out, sdi = 1'b0, sdo;

   int n_chk = 0, n_fail = 0;

   always #5 clk = ~clk;

   sio_port dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .dir_reg(dir_reg), .pin_oe(pin_oe),
      .sck_in(sck_in), .sck_out(sck_out), .sdi(sdi), .sdo(sdo)
   );

   function automatic logic [2:0] exp_oe(input logic en, input logic slv, input logic [2:0] dir);
      if (!en) return dir;
      return {1'b1, dir[1], ~slv};
   endfunction

   function automatic logic [7:0] exp_ctrl(input logic [7:0] mode_bits, input logic go,
                                           input logic done, input logic wcol, input logic ovr);
      return (mode_bits & (C_EN | C_SLV | C_POL)) | (go ? C_GO : 8'h00) |
             (done ? C_DONE : 8'h00) | (wcol ? C_WCOL : 8'h00) | (ovr ? C_OVR : 8'h00);
   endfunction

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic a, output logic [7:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   // master transfer with a bench-side slave model
   task automatic master_xfer(input logic pol, input logic [7:0] tx, input logic [7:0] sb,
                              output logic [7:0] got_s, output int pulses,
                              output logic half_ok, output logic go_mid);
      logic prev, now;
      int   alen, k;
      wr(1'b0, C_EN | (pol ? C_POL : 8'h00));
      wr(1'b1, tx);
      sdi = sb[7];
      k = 0; pulses = 0; alen = 0; half_ok = 1'b1; go_mid = 1'b0; got_s = '0;
      wr(1'b0, C_EN | C_GO | (pol ? C_POL : 8'h00));
      addr = 1'b0;
      prev = pol;
      for (int c = 0; c < 50; c++) begin
         @(negedge clk);
         now = sck_out;
         if (prev == pol && now != pol) begin
            got_s = {got_s[6:0], sdo};
            pulses++;
            alen = 1;
            if (pulses == 4) go_mid = rdata[2];
         end else if (now != pol) begin
            alen++;
         end else if (prev != pol) begin
            if (alen != HALF_CYC) half_ok = 1'b0;
            k++;
            sdi = (k < 8) ? sb[7-k] : 1'b0;
         end
         prev = now;
      end
   endtask

   // slave transfer with the bench acting as clock master
   task automatic slave_xfer(input logic pol, input logic [7:0] tx, input logic [7:0] mb,
                             input logic collide, output logic [7:0] got_b);
      sck_in = pol;
      wr(1'b0, C_EN | C_SLV | (pol ? C_POL : 8'h00));
      wr(1'b1, tx);
      wr(1'b0, C_EN | C_SLV | C_GO | (pol ? C_POL : 8'h00));
      got_b = '0;
      for (int i = 0; i < 8; i++) begin
         if (collide && i == 3) wr(1'b1, 8'h3C);
         sdi = mb[7-i];
         repeat (SHP) @(negedge clk);
         got_b = {got_b[6:0], sdo};
         sck_in = ~pol;
         repeat (SHP) @(negedge clk);
         sck_in = pol;
      end
      repeat (SHP) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      logic [7:0] v, got_s, got_m, tx, sb;
      logic       pol, half_ok, go_mid;
      int         pulses;
      void'($urandom(32'h51A7));

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(pin_oe, dir_reg, "R1 pin_oe after reset");
      chk(sck_out, 0, "R1 sck_out after reset");
      rd(1'b0, v); chk(v, 8'h00, "R1 control after reset");
      rd(1'b1, v); chk(v, 8'h00, "R1 data after reset");

      // R2 disabled: directions follow dir_reg
      for (int i = 0; i < 4; i++) begin
         dir_reg = 3'($urandom);
         #1 chk(pin_oe, exp_oe(1'b0, 1'b0, dir_reg), "R2 disabled pin_oe");
      end

      // R3 master enabled
      wr(1'b0, C_EN);
      foreach (dir_reg[j]) begin
         dir_reg = 3'(1 << j);
         #1 chk(pin_oe, exp_oe(1'b1, 1'b0, dir_reg), "R3 master pin_oe");
      end
      // R4 slave enabled
      wr(1'b0, C_EN | C_SLV);
      dir_reg = 3'b111; #1 chk(pin_oe, exp_oe(1'b1, 1'b1, dir_reg), "R4 slave pin_oe all-out dir");
      dir_reg = 3'b000; #1 chk(pin_oe, exp_oe(1'b1, 1'b1, dir_reg), "R4 slave pin_oe all-in dir");
      wr(1'b0, 8'h00);
      dir_reg = 3'b011; #1 chk(pin_oe, 3'b011, "R2 handed back after disable");

      // R11 enable and start in one write
      wr(1'b0, C_EN | C_GO);
      rd(1'b0, v); chk(v, exp_ctrl(C_EN, 0, 0, 0, 0), "R11 enable+start gives EN only");
      begin
         logic moved;
         moved = 1'b0;
         for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (sck_out !== 1'b0) moved = 1'b1;
         end
         chk(moved, 0, "R11 no clock after illegal start");
      end
      rd(1'b0, v); chk(v[2], 0, "R11 GO still 0");

      // R5 R7 R8 directed master transfer, POL=0
      master_xfer(1'b0, 8'hA5, 8'h3C, got_s, pulses, half_ok, go_mid);
      chk(pulses, 8, "R5 master pulse count");
      chk(half_ok, 1, "R5 master pulse width");
      chk(go_mid, 1, "R5 GO during transfer");
      chk(got_s, 8'hA5, "R8 master tx MSB first");
      rd(1'b0, v); chk(v, exp_ctrl(C_EN, 0, 1, 0, 0), "R5 DONE set GO clear");
      rd(1'b1, got_m); chk(got_m, 8'h3C, "R8 master rx MSB first");
      // R10 write does not change read value
      wr(1'b1, 8'h77);
      rd(1'b1, v); chk(v, 8'h3C, "R10 data write leaves held byte");

      // R7 POL=1 idle level
      wr(1'b0, C_EN | C_POL | C_DONE);
      @(negedge clk); chk(sck_out, 1, "R7 idle high with POL=1");

      // random master transfers, both polarities
      for (int i = 0; i < 6; i++) begin
         pol = 1'($urandom); tx = 8'($urandom); sb = 8'($urandom);
         master_xfer(pol, tx, sb, got_s, pulses, half_ok, go_mid);
         chk(pulses, 8, "R5 random master pulses");
         chk(got_s, tx, "R7 R8 random master sent byte");
         rd(1'b1, got_m); chk(got_m, sb, "R7 R8 random master received byte");
      end

      // R6 slave transfers
      for (int i = 0; i < 4; i++) begin
         pol = 1'(i); tx = 8'($urandom); sb = 8'($urandom);
         slave_xfer(pol, tx, sb, 1'b0, got_s);
         chk(got_s, tx, "R6 R8 slave sent byte");
         rd(1'b0, v);
         chk(v, exp_ctrl(C_EN | C_SLV | (pol ? C_POL : 8'h00), 0, 1, 0, 0), "R6 slave DONE");
         rd(1'b1, got_m); chk(got_m, sb, "R6 R7 slave received byte");
      end

      // R9 write collision during slave transfer
      slave_xfer(1'b0, 8'hC3, 8'h5A, 1'b1, got_s);
      chk(got_s, 8'hC3, "R9 colliding write ignored");
      rd(1'b0, v); chk(v, exp_ctrl(C_EN | C_SLV, 0, 1, 1, 0), "R9 WCOL set");
      rd(1'b1, v); chk(v, 8'h5A, "R9 received byte intact");
      wr(1'b0, C_EN | C_WCOL);
      rd(1'b0, v); chk(v[5], 0, "R12 WCOL cleared by write 1");

      // R10 overrun: two transfers without reading
      master_xfer(1'b0, 8'h11, 8'h81, got_s, pulses, half_ok, go_mid);
      master_xfer(1'b0, 8'h22, 8'h42, got_s, pulses, half_ok, go_mid);
      rd(1'b0, v); chk(v, exp_ctrl(C_EN, 0, 1, 0, 1), "R10 OVR after unread byte");
      rd(1'b1, v); chk(v, 8'h42, "R10 newest byte kept");
      // R12 W1C rules
      wr(1'b0, C_EN | C_OVR);
      rd(1'b0, v); chk(v, exp_ctrl(C_EN, 0, 1, 0, 0), "R12 OVR cleared DONE kept");
      wr(1'b0, C_EN);
      rd(1'b0, v); chk(v[4], 1, "R12 writing 0 keeps DONE");
      // after a read, the next completion gives no overrun; start clears DONE
      master_xfer(1'b0, 8'h33, 8'h99, got_s, pulses, half_ok, go_mid);
      rd(1'b0, v); chk(v[6], 0, "R10 no OVR after read");
      wr(1'b0, C_EN | C_DONE);
      rd(1'b0, v); chk(v, exp_ctrl(C_EN, 0, 0, 0, 0), "R12 DONE cleared by write 1");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule